// File: doc/BRIEF.md
# Dual-Table Next-Fetch Predictor

This block predicts where instruction fetch goes next. It keeps two direct-mapped target tables. The near table stores short jumps made by compressed control-flow instructions whose target lies inside the fetch block that holds the branch. Because the upper address bits of such a target are known, only the in-block offset is stored. The far table stores every other taken branch together with its full target address. A fetch address is looked up in both tables at once. A hit in the near table always decides the prediction, even when the far table also hits.

The resolved-branch port trains the tables. A taken outcome writes an entry into the one table picked by the near/far classification. A not-taken outcome is treated as a branch to PC+2, and the classification of PC+2 does not matter for it. Any matching entry in either table has its taken bit cleared, and no new entry is ever created. This stops a stale near entry from winning over a far entry and trapping fetch in a loop when PC+2 crosses a block boundary.

Top module: `btb_dual`

## Requirements
- R1: After a synchronous reset, every entry in both tables is invalid, so any lookup returns pred_taken=0.
- R2: When no table hits, pred_taken is 0 and pred_next_pc is the start of the next 16-byte fetch block ({fetch_pc[31:4]+1, 4'b0}).
- R3: A taken update with upd_compressed=1 whose target has the same bits [31:4] as upd_pc goes to the near table. A later lookup of that PC returns pred_taken=1 and the stored target. A taken update also re-arms an entry whose taken bit was cleared.
- R4: A taken update that is not compressed, or whose target lies in another 16-byte block, goes to the far table. A later lookup returns pred_taken=1 and the full target.
- R5: When both tables hit for one fetch PC, the near entry decides both pred_taken and pred_next_pc, even when its taken bit is clear and the far entry is taken.
- R6: A not-taken update clears the taken bit of the matching entry in both tables, whether or not PC+2 crosses a block boundary. Lookups of that PC then give pred_taken=0 and the sequential address.
- R7: A not-taken update never allocates and never disturbs an entry whose tag differs, including an entry at the same index.
- R8: An entry hits only when it is valid and its tag (bits [31:7]) equals that of fetch_pc. The index is bits [6:1].
- R9: Lookup is combinational. An update takes effect at the clock edge and is not forwarded to a lookup in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched |
| pred_taken | output | 1 | Predicted redirect |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved target when taken |
| upd_taken | input | 1 | Branch outcome |
| upd_compressed | input | 1 | Branch is a 16-bit instruction |

## Verification
Checked on every cycle are the clearing after reset, that a not-taken update leaves the valid bits alone, that a matching entry loses its taken bit after a not-taken update, that an allocation makes its slot valid, and that a near-table redirect stays inside the fetch block. Only the bench scenarios can show the classification of updates, the near-table priority over a taken far entry, the not-taken update that crosses a block boundary, alias protection at one index and the absence of same-cycle forwarding. Each of these needs a sequence of updates followed by lookups.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic {
    SEL_NEAR = 1'b0,
    SEL_FAR  = 1'b1
  } btb_sel_e;
endpackage

// File: rtl/btb_classify.sv
module btb_classify
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int BLK_W = 4
) (
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] target,
  input  logic            taken,
  input  logic            compressed,
  output logic [PC_W-1:0] eff_target,
  output btb_sel_e        sel
);
  localparam logic [PC_W-1:0] HALF_STEP = PC_W'(2);

  // A not-taken outcome is modelled as a jump to the next halfword.
  always_comb begin
    eff_target = taken ? target : pc + HALF_STEP;
    if (compressed && (eff_target[PC_W-1:BLK_W] == pc[PC_W-1:BLK_W]))
      sel = SEL_NEAR;
    else
      sel = SEL_FAR;
  end
endmodule

// File: rtl/btb_table.sv
module btb_table #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 25,
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic             lk_taken,
  output logic [TGT_W-1:0] lk_tgt,
  input  logic [IDX_W-1:0] up_idx,
  input  logic [TAG_W-1:0] up_tag,
  input  logic             up_alloc,
  input  logic [TGT_W-1:0] up_tgt,
  input  logic             up_mark
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] taken_q;
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [TGT_W-1:0] tgt_mem [DEPTH];
  logic             up_hit;

  // Payload RAM: write only, no reset, so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (up_alloc) begin
      tag_mem[up_idx] <= up_tag;
      tgt_mem[up_idx] <= up_tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      taken_q <= '0;
    end else if (up_alloc) begin
      valid_q[up_idx] <= 1'b1;
      taken_q[up_idx] <= 1'b1;
    end else if (up_mark && up_hit) begin
      taken_q[up_idx] <= 1'b0;
    end
  end

  always_comb begin
    up_hit   = valid_q[up_idx] && (tag_mem[up_idx] == up_tag);
    lk_hit   = valid_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
    lk_taken = taken_q[lk_idx];
    lk_tgt   = tgt_mem[lk_idx];
  end

  // R1: reset leaves no valid entry
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (valid_q == '0));
  // R7: a not-taken update never creates an entry
  a_r7_mark_no_alloc: assert property (@(posedge clk) disable iff (rst)
    (up_mark && !up_alloc) |=> $stable(valid_q));
  // R6: a matching entry loses its taken bit
  a_r6_mark_clears: assert property (@(posedge clk) disable iff (rst)
    (up_mark && !up_alloc && up_hit) |=> !taken_q[$past(up_idx)]);
  // R3: allocation leaves the slot valid and taken
  a_r3_alloc_valid: assert property (@(posedge clk) disable iff (rst)
    up_alloc |=> (valid_q[$past(up_idx)] && taken_q[$past(up_idx)]));
endmodule

// File: rtl/btb_dual.sv
module btb_dual
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int BLK_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_taken,
  input  logic            upd_compressed
);
  localparam int TAG_W = PC_W - IDX_W - 1;
  localparam int HI_W  = PC_W - BLK_W;
  localparam logic [HI_W-1:0] BLK_ONE = HI_W'(1);

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [PC_W-1:0]  eff_target, seq_pc;
  btb_sel_e         up_sel;
  logic             near_alloc, far_alloc, any_mark;
  logic             near_hit, near_taken, far_hit, far_taken;
  logic [BLK_W-1:0] near_tgt;
  logic [PC_W-1:0]  far_tgt;
  logic             unused_bits;

  assign lk_idx = fetch_pc[IDX_W:1];
  assign lk_tag = fetch_pc[PC_W-1:IDX_W+1];
  assign up_idx = upd_pc[IDX_W:1];
  assign up_tag = upd_pc[PC_W-1:IDX_W+1];
  assign unused_bits = &{1'b0, fetch_pc[0], upd_pc[0]};

  btb_classify #(.PC_W(PC_W), .BLK_W(BLK_W)) i_classify (
    .pc(upd_pc), .target(upd_target), .taken(upd_taken),
    .compressed(upd_compressed), .eff_target(eff_target), .sel(up_sel)
  );

  // Taken updates go to one table; not-taken updates mark both tables.
  assign near_alloc = upd_valid && upd_taken && (up_sel == SEL_NEAR);
  assign far_alloc  = upd_valid && upd_taken && (up_sel == SEL_FAR);
  assign any_mark   = upd_valid && !upd_taken;

  btb_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(BLK_W)) i_near (
    .clk(clk), .rst(rst),
    .lk_idx(lk_idx), .lk_tag(lk_tag),
    .lk_hit(near_hit), .lk_taken(near_taken), .lk_tgt(near_tgt),
    .up_idx(up_idx), .up_tag(up_tag), .up_alloc(near_alloc),
    .up_tgt(eff_target[BLK_W-1:0]), .up_mark(any_mark)
  );

  btb_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(PC_W)) i_far (
    .clk(clk), .rst(rst),
    .lk_idx(lk_idx), .lk_tag(lk_tag),
    .lk_hit(far_hit), .lk_taken(far_taken), .lk_tgt(far_tgt),
    .up_idx(up_idx), .up_tag(up_tag), .up_alloc(far_alloc),
    .up_tgt(eff_target), .up_mark(any_mark)
  );

  assign seq_pc = {fetch_pc[PC_W-1:BLK_W] + BLK_ONE, {BLK_W{1'b0}}};

  // The near table wins whenever it hits.
  always_comb begin
    pred_taken   = 1'b0;
    pred_next_pc = seq_pc;
    if (near_hit) begin
      if (near_taken) begin
        pred_taken   = 1'b1;
        pred_next_pc = {fetch_pc[PC_W-1:BLK_W], near_tgt};
      end
    end else if (far_hit && far_taken) begin
      pred_taken   = 1'b1;
      pred_next_pc = far_tgt;
    end
  end

  // R2: without a redirect, fetch moves to the next block
  a_r2_seq_fallthrough: assert property (@(posedge clk) disable iff (rst)
    !pred_taken |-> (pred_next_pc[PC_W-1:BLK_W] == fetch_pc[PC_W-1:BLK_W] + BLK_ONE));
  // R5: a near hit never redirects out of the fetch block
  a_r5_near_in_block: assert property (@(posedge clk) disable iff (rst)
    (near_hit && pred_taken) |-> (pred_next_pc[PC_W-1:BLK_W] == fetch_pc[PC_W-1:BLK_W]));
endmodule

// File: tb/test_btb_dual.sv
module test_btb_dual;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = '0;
  logic        pred_taken;
  logic [31:0] pred_next_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_target = '0;
  logic        upd_taken = 1'b0;
  logic        upd_compressed = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  btb_dual i_btb_dual (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_taken(upd_taken), .upd_compressed(upd_compressed)
  );

  typedef struct packed {
    logic        is_upd;
    logic [31:0] pc;
    logic [31:0] tgt;
    logic        tk;
    logic        cmp;
    logic        exp_tk;
    logic [31:0] exp_nx;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h1000, 32'h0,    1'b0, 1'b0, 1'b0, 32'h1010, 4'd1}, // R1 empty
    '{1'b1, 32'h1002, 32'h100A, 1'b1, 1'b1, 1'b0, 32'h0,    4'd3},
    '{1'b0, 32'h1002, 32'h0,    1'b0, 1'b0, 1'b1, 32'h100A, 4'd3}, // R3 near
    '{1'b1, 32'h2004, 32'h3000, 1'b1, 1'b0, 1'b0, 32'h0,    4'd4},
    '{1'b0, 32'h2004, 32'h0,    1'b0, 1'b0, 1'b1, 32'h3000, 4'd4}, // R4 far
    '{1'b1, 32'h2100, 32'h2108, 1'b1, 1'b0, 1'b0, 32'h0,    4'd4},
    '{1'b0, 32'h2100, 32'h0,    1'b0, 1'b0, 1'b1, 32'h2108, 4'd4}, // R4 not compressed
    '{1'b1, 32'h400C, 32'h4010, 1'b1, 1'b1, 1'b0, 32'h0,    4'd4},
    '{1'b0, 32'h400C, 32'h0,    1'b0, 1'b0, 1'b1, 32'h4010, 4'd4}, // R4 crosses block
    '{1'b0, 32'h1082, 32'h0,    1'b0, 1'b0, 1'b0, 32'h1090, 4'd8}, // R8 alias miss
    '{1'b1, 32'h500E, 32'h5002, 1'b1, 1'b1, 1'b0, 32'h0,    4'd5},
    '{1'b1, 32'h500E, 32'h7000, 1'b1, 1'b0, 1'b0, 32'h0,    4'd5},
    '{1'b0, 32'h500E, 32'h0,    1'b0, 1'b0, 1'b1, 32'h5002, 4'd5}, // R5 near wins
    '{1'b1, 32'h500E, 32'h0,    1'b0, 1'b1, 1'b0, 32'h0,    4'd6},
    '{1'b0, 32'h500E, 32'h0,    1'b0, 1'b0, 1'b0, 32'h5010, 4'd6}, // R6 both marked
    '{1'b1, 32'h500E, 32'h7000, 1'b1, 1'b0, 1'b0, 32'h0,    4'd5},
    '{1'b0, 32'h500E, 32'h0,    1'b0, 1'b0, 1'b0, 32'h5010, 4'd5}, // R5 cleared near wins
    '{1'b1, 32'h1082, 32'h0,    1'b0, 1'b1, 1'b0, 32'h0,    4'd7},
    '{1'b0, 32'h1002, 32'h0,    1'b0, 1'b0, 1'b1, 32'h100A, 4'd7}, // R7 alias untouched
    '{1'b0, 32'h1082, 32'h0,    1'b0, 1'b0, 1'b0, 32'h1090, 4'd7}, // R7 no alloc
    '{1'b1, 32'h1002, 32'h0,    1'b0, 1'b1, 1'b0, 32'h0,    4'd6},
    '{1'b0, 32'h1002, 32'h0,    1'b0, 1'b0, 1'b0, 32'h1010, 4'd6}, // R6 in-block mark
    '{1'b1, 32'h1002, 32'h100A, 1'b1, 1'b1, 1'b0, 32'h0,    4'd3},
    '{1'b0, 32'h1002, 32'h0,    1'b0, 1'b0, 1'b1, 32'h100A, 4'd3}  // R3 re-armed
  };

  task automatic check(input int req, input logic exp_tk, input logic [31:0] exp_nx);
    checks++;
    if (pred_taken !== exp_tk || pred_next_pc !== exp_nx) begin
      fails++;
      $display("FAIL R%0d pc=%h actual taken=%0b next=%h expected taken=%0b next=%h",
               req, fetch_pc, pred_taken, pred_next_pc, exp_tk, exp_nx);
    end
  endtask

  task automatic do_update(input logic [31:0] pc, input logic [31:0] tgt,
                           input logic tk, input logic cmp);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_target = tgt;
    upd_taken = tk; upd_compressed = cmp;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [31:0] pc, input int req,
                           input logic exp_tk, input logic [31:0] exp_nx);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    check(req, exp_tk, exp_nx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_upd)
        do_update(VEC[i].pc, VEC[i].tgt, VEC[i].tk, VEC[i].cmp);
      else
        do_lookup(VEC[i].pc, int'(VEC[i].req), VEC[i].exp_tk, VEC[i].exp_nx);
    end

    // R9: same-cycle update is not forwarded
    @(negedge clk);
    fetch_pc = 32'h6000;
    upd_valid = 1'b1; upd_pc = 32'h6000; upd_target = 32'h6100;
    upd_taken = 1'b1; upd_compressed = 1'b0;
    #1;
    check(9, 1'b0, 32'h6010);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    check(9, 1'b1, 32'h6100);

    // R2: miss in a fresh region
    do_lookup(32'h8FF4, 2, 1'b0, 32'h9000);

    // R1: reset in mid-run wipes both tables
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    do_lookup(32'h1002, 1, 1'b0, 32'h1010);
    do_lookup(32'h2004, 1, 1'b0, 32'h2010);
    do_lookup(32'h6000, 1, 1'b0, 32'h6010);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule